// File: doc/BRIEF.md
# PWM Timebase with Event Action Qualifier

This block generates two pulse-width-modulated outputs from one up-counting timebase. A two-stage divider turns the system clock into a slower count clock. On each count tick a 16-bit counter moves up by one, and after it reaches a programmable period value it returns to zero. On every tick the block looks at the value the counter holds. A match with zero, with the period, or with either of two compare values is an event. A per-output action table decides whether each event drives that output low, drives it high, toggles it, or leaves it as it is.

Compare values are written to shadow registers. By default a shadow value reaches its comparator only when the counter is at zero, so a duty change never splits a period. An immediate mode bypasses the shadow. One selectable counter event can set a sticky interrupt flag, and software clears the flag through a write. A synchronous enable starts and stops the whole timebase. Configuration arrives through a simple single-cycle write port.

Top module: `pwm_aq_top`

## Requirements
- R1: After reset the counter reads 0, both outputs are low and the interrupt flag is clear. All configuration registers are 0, which selects divide-by-1 and "no action" for every event.
- R2: Address 0 is the control register. Bits [2:0] are the low-speed code L and bits [5:3] are the high-speed code H. While enabled, the counter advances once every (2^L) x (H==0 ? 1 : 2H) system cycles, counted from the cycle enable is first sampled high.
- R3: Address 1 is the period P. On a tick the counter goes to 0 if it holds P or more, and otherwise to its value plus one. A full period therefore lasts P+1 ticks.
- R4: Addresses 4 and 5 are the action registers of output A and output B. Each has 2-bit codes for these events: counter zero at bits [1:0], counter equals period at [3:2], counter equals compare A at [5:4] and counter equals compare B at [9:8]. Code 0 holds the output, 1 drives it low, 2 drives it high and 3 toggles it. An output changes only on a tick, in the same clock edge in which the counter leaves the value that caused the event.
- R5: When several events with a non-zero code meet on one tick, the compare-B code has highest priority, followed by compare A, then period, then zero.
- R6: Addresses 2 and 3 hold compare A and compare B. Take an output set high at zero and driven low at its compare value C. For 0 < C <= P it is high for C ticks of every period. For C = 0 it is always low, and for C > P it is always high.
- R7: Control bit 6 selects the compare load mode. With bit 6 at 0, a written compare value is used from the tick at which the counter is 0. With bit 6 at 1, it is used from the first tick after the write.
- R8: Address 6 is the event-select register. Bit 2 enables the interrupt, and bits [1:0] choose the event: 0 = zero, 1 = period, 2 = compare A, 3 = compare B. The flag rises at the edge of the tick on which the chosen event occurs. With bit 2 at 0 the flag never sets.
- R9: A write to address 7 with data bit 0 set clears the flag. A write there with bit 0 clear has no effect. If a clear and a new event fall in the same cycle, the flag stays set.
- R10: While enable is low, the counter is held at 0, both outputs are low, and the divider restarts. Register writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Synchronous run enable for counter and outputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Register write data |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |
| cnt_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The hardest case to reach is a flag clear that lands in exactly the same cycle as a new selected event. To set it up, the bench waits until it sees the counter holding the period value at a falling edge. It then issues the clear write at once, so the write and the period tick are sampled at the same rising edge. The shadow-load behaviour needs similar placement: the bench writes a new compare value partway through a period and checks the output before the next zero. A behavioural model runs alongside the design and is compared with the counter, both outputs and the flag on every cycle.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int unsigned ADDR_W = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA    = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPB    = 3'd3;
    localparam logic [ADDR_W-1:0] A_ACTA    = 3'd4;
    localparam logic [ADDR_W-1:0] A_ACTB    = 3'd5;
    localparam logic [ADDR_W-1:0] A_EVSEL   = 3'd6;
    localparam logic [ADDR_W-1:0] A_FLAGCLR = 3'd7;

    // field positions inside an action register
    localparam int unsigned ZRO_LSB = 0;
    localparam int unsigned PRD_LSB = 2;
    localparam int unsigned CAU_LSB = 4;
    localparam int unsigned CBU_LSB = 8;

    // event-select register layout
    localparam int unsigned EV_EN_BIT = 2;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        SEL_ZRO = 2'd0,
        SEL_PRD = 2'd1,
        SEL_CAU = 2'd2,
        SEL_CBU = 2'd3
    } evsel_e;

    typedef struct packed {
        act_e cbu;
        act_e cau;
        act_e prd;
        act_e zro;
    } act_cfg_t;

    typedef struct packed {
        logic cbu;
        logic cau;
        logic prd;
        logic zro;
    } evt_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LS_W  = 3,
    parameter int unsigned HS_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [LS_W-1:0]   ls_code_o,
    output logic [HS_W-1:0]   hs_code_o,
    output logic              imm_load_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  cmpa_o,
    output logic [CNT_W-1:0]  cmpb_o,
    output act_cfg_t          act_a_o,
    output act_cfg_t          act_b_o,
    output logic              ev_en_o,
    output evsel_e            ev_sel_o,
    output logic              flag_clr_o
);

    localparam int unsigned HS_LSB  = LS_W;
    localparam int unsigned IMM_BIT = LS_W + HS_W;

    typedef struct packed {
        logic [LS_W-1:0]  ls;
        logic [HS_W-1:0]  hs;
        logic             imm;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] cmpa;
        logic [CNT_W-1:0] cmpb;
        act_cfg_t         act_a;
        act_cfg_t         act_b;
        logic             ev_en;
        evsel_e           ev_sel;
    } regs_t;

    regs_t r_d, r_q;

    function automatic act_cfg_t to_act(input logic [CNT_W-1:0] d);
        act_cfg_t c;
        c.zro = act_e'(d[ZRO_LSB +: 2]);
        c.prd = act_e'(d[PRD_LSB +: 2]);
        c.cau = act_e'(d[CAU_LSB +: 2]);
        c.cbu = act_e'(d[CBU_LSB +: 2]);
        return c;
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                A_CTRL: begin
                    r_d.ls  = wr_data_i[LS_W-1:0];
                    r_d.hs  = wr_data_i[HS_LSB +: HS_W];
                    r_d.imm = wr_data_i[IMM_BIT];
                end
                A_PERIOD: r_d.period = wr_data_i;
                A_CMPA:   r_d.cmpa   = wr_data_i;
                A_CMPB:   r_d.cmpb   = wr_data_i;
                A_ACTA:   r_d.act_a  = to_act(wr_data_i);
                A_ACTB:   r_d.act_b  = to_act(wr_data_i);
                A_EVSEL: begin
                    r_d.ev_en  = wr_data_i[EV_EN_BIT];
                    r_d.ev_sel = evsel_e'(wr_data_i[1:0]);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign ls_code_o  = r_q.ls;
    assign hs_code_o  = r_q.hs;
    assign imm_load_o = r_q.imm;
    assign period_o   = r_q.period;
    assign cmpa_o     = r_q.cmpa;
    assign cmpb_o     = r_q.cmpb;
    assign act_a_o    = r_q.act_a;
    assign act_b_o    = r_q.act_b;
    assign ev_en_o    = r_q.ev_en;
    assign ev_sel_o   = r_q.ev_sel;
    assign flag_clr_o = wr_en_i && (wr_addr_i == A_FLAGCLR) && wr_data_i[0];

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned LS_W = 3,
    parameter int unsigned HS_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            run_i,
    input  logic [LS_W-1:0] ls_code_i,
    input  logic [HS_W-1:0] hs_code_i,
    output logic            tick_o
);

    // low stage divides by 2^code, high stage by 1 or 2*code
    localparam int unsigned LS_CNT_W = 1 << LS_W;
    localparam int unsigned HS_CNT_W = HS_W + 1;

    typedef struct packed {
        logic [LS_CNT_W-1:0] ls;
        logic [HS_CNT_W-1:0] hs;
    } pre_t;

    pre_t s_d, s_q;
    logic [LS_CNT_W-1:0] ls_lim;
    logic [HS_CNT_W-1:0] hs_lim;

    always_comb begin
        ls_lim = (LS_CNT_W'(1) << ls_code_i) - LS_CNT_W'(1);
        hs_lim = (hs_code_i == '0) ? '0 : ({hs_code_i, 1'b0} - HS_CNT_W'(1));
        s_d    = s_q;
        tick_o = 1'b0;
        if (!run_i) begin
            s_d = '0;
        end else if (s_q.ls >= ls_lim) begin
            s_d.ls = '0;
            if (s_q.hs >= hs_lim) begin
                s_d.hs = '0;
                tick_o = 1'b1;
            end else begin
                s_d.hs = s_q.hs + HS_CNT_W'(1);
            end
        end else begin
            s_d.ls = s_q.ls + LS_CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             imm_load_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmpa_i,
    input  logic [CNT_W-1:0] cmpb_i,
    output logic [CNT_W-1:0] cnt_o,
    output evt_t             evt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmpa;
        logic [CNT_W-1:0] cmpb;
    } tb_t;

    tb_t s_d, s_q;
    logic at_zero, use_new;
    logic [CNT_W-1:0] eff_a, eff_b;

    always_comb begin
        at_zero = (s_q.cnt == '0);
        // the value being loaded at zero already governs that tick
        use_new = imm_load_i || at_zero;
        eff_a   = use_new ? cmpa_i : s_q.cmpa;
        eff_b   = use_new ? cmpb_i : s_q.cmpb;

        evt_o.zro = tick_i && at_zero;
        evt_o.prd = tick_i && (s_q.cnt == period_i);
        evt_o.cau = tick_i && (s_q.cnt == eff_a);
        evt_o.cbu = tick_i && (s_q.cnt == eff_b);

        s_d = s_q;
        if (imm_load_i || (tick_i && at_zero)) begin
            s_d.cmpa = cmpa_i;
            s_d.cmpb = cmpb_i;
        end
        if (!run_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            s_d.cnt = (s_q.cnt >= period_i) ? '0 : s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

endmodule

// File: rtl/pwm_action.sv
module pwm_action
    import pwm_aq_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     run_i,
    input  evt_t     evt_i,
    input  act_cfg_t cfg_i,
    output logic     pwm_o
);

    logic pwm_d, pwm_q;
    act_e sel;

    always_comb begin
        // later lines override earlier ones: lowest priority first
        sel = ACT_HOLD;
        if (evt_i.zro && cfg_i.zro != ACT_HOLD) sel = cfg_i.zro;
        if (evt_i.prd && cfg_i.prd != ACT_HOLD) sel = cfg_i.prd;
        if (evt_i.cau && cfg_i.cau != ACT_HOLD) sel = cfg_i.cau;
        if (evt_i.cbu && cfg_i.cbu != ACT_HOLD) sel = cfg_i.cbu;

        unique case (sel)
            ACT_LOW:    pwm_d = 1'b0;
            ACT_HIGH:   pwm_d = 1'b1;
            ACT_TOGGLE: pwm_d = ~pwm_q;
            default:    pwm_d = pwm_q;
        endcase
        if (!run_i) pwm_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pwm_q <= 1'b0;
        else         pwm_q <= pwm_d;
    end

    assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LS_W  = 3,
    parameter int unsigned HS_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic              pwm_a_o,
    output logic              pwm_b_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_o
);

    localparam int unsigned N_CH = 2;

    logic [LS_W-1:0]  ls_code;
    logic [HS_W-1:0]  hs_code;
    logic             imm_load;
    logic [CNT_W-1:0] period, cmpa, cmpb;
    act_cfg_t         act_cfg [N_CH];
    logic             ev_en;
    evsel_e           ev_sel;
    logic             flag_clr;
    logic             tick;
    evt_t             evt;
    logic [N_CH-1:0]  pwm;

    pwm_regs #(.CNT_W(CNT_W), .LS_W(LS_W), .HS_W(HS_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .ls_code_o  (ls_code),
        .hs_code_o  (hs_code),
        .imm_load_o (imm_load),
        .period_o   (period),
        .cmpa_o     (cmpa),
        .cmpb_o     (cmpb),
        .act_a_o    (act_cfg[0]),
        .act_b_o    (act_cfg[1]),
        .ev_en_o    (ev_en),
        .ev_sel_o   (ev_sel),
        .flag_clr_o (flag_clr)
    );

    pwm_prescaler #(.LS_W(LS_W), .HS_W(HS_W)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (en_i),
        .ls_code_i (ls_code),
        .hs_code_i (hs_code),
        .tick_o    (tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (en_i),
        .tick_i     (tick),
        .imm_load_i (imm_load),
        .period_i   (period),
        .cmpa_i     (cmpa),
        .cmpb_i     (cmpb),
        .cnt_o      (cnt_o),
        .evt_o      (evt)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        pwm_action u_act (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .run_i  (en_i),
            .evt_i  (evt),
            .cfg_i  (act_cfg[ch]),
            .pwm_o  (pwm[ch])
        );
    end

    assign pwm_a_o = pwm[0];
    assign pwm_b_o = pwm[1];

    typedef struct packed {
        logic irq;
    } flag_t;

    flag_t flag_d, flag_q;
    logic  sel_evt, flag_hit;

    always_comb begin
        unique case (ev_sel)
            SEL_ZRO: sel_evt = evt.zro;
            SEL_PRD: sel_evt = evt.prd;
            SEL_CAU: sel_evt = evt.cau;
            default: sel_evt = evt.cbu;
        endcase
        flag_hit = ev_en && sel_evt;
        flag_d   = flag_q;
        if (flag_hit)      flag_d.irq = 1'b1;
        else if (flag_clr) flag_d.irq = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= '0;
        else         flag_q <= flag_d;
    end

    assign irq_o = flag_q.irq;

endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             tick_i,
    input logic             flag_hit_i,
    input logic             flag_clr_i,
    input logic             pwm_a_i,
    input logic             pwm_b_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             irq_i
);

    // R2: without a divider tick the counter does not move while running
    assert_no_tick_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(cnt_i));

    // R3: the counter only steps by one or returns to zero
    assert_step_or_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1 || cnt_i == '0));

    // R4: outputs change only on a tick
    assert_out_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> ($stable(pwm_a_i) && $stable(pwm_b_i)));

    // R10: disabled means counter at zero and outputs low
    assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_i == '0 && !pwm_a_i && !pwm_b_i));

    // R9: the flag stays set until a clear arrives
    assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i && !flag_clr_i) |=> irq_i);

    // R9: an event sets the flag even when a clear comes with it
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_hit_i |=> irq_i);

endmodule

bind pwm_aq_top pwm_aq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick),
    .flag_hit_i (flag_hit),
    .flag_clr_i (flag_clr),
    .pwm_a_i    (pwm_a_o),
    .pwm_b_i    (pwm_b_o),
    .cnt_i      (cnt_o),
    .irq_i      (irq_o)
);

// File: tb/tb_pwm_aq_top.sv
module tb_pwm_aq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b, irq;
    logic [15:0] cnt;

    int n_checks = 0;
    int n_err = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_aq_top dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_i      (en),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .pwm_a_o   (pwm_a),
        .pwm_b_o   (pwm_b),
        .cnt_o     (cnt),
        .irq_o     (irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int          m_cnt, m_pc, m_n, m_ca_act, m_cb_act, m_ca_eff, m_cb_eff;
    logic [15:0] m_prd, m_ca, m_cb, m_acta, m_actb;
    logic [6:0]  m_ctrl;
    logic [2:0]  m_evsel;
    bit          m_a, m_b, m_irq, m_tick, m_use;
    bit [3:0]    m_ev;   // {cmpB, cmpA, period, zero}

    function automatic bit apply(input bit cur, input logic [15:0] cfg, input bit [3:0] ev);
        int pos[4] = '{0, 2, 4, 8};
        int win = -1;
        for (int i = 3; i >= 0; i--)
            if (win < 0 && ev[i] && cfg[pos[i] +: 2] != 2'd0) win = i;
        if (win < 0) return cur;
        case (cfg[pos[win] +: 2])
            2'd1:    return 1'b0;
            2'd2:    return 1'b1;
            default: return !cur;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_ca_act = 0; m_cb_act = 0;
            m_prd = 0; m_ca = 0; m_cb = 0; m_acta = 0; m_actb = 0;
            m_ctrl = 0; m_evsel = 0; m_a = 0; m_b = 0; m_irq = 0;
        end else begin
            m_n = (1 << m_ctrl[2:0]) * ((m_ctrl[5:3] == 0) ? 1 : 2 * int'(m_ctrl[5:3]));
            m_tick = 0;
            if (!en) m_pc = 0;
            else begin
                m_pc++;
                if (m_pc >= m_n) begin m_tick = 1; m_pc = 0; end
            end
            m_ev = 0;
            if (m_tick) begin
                m_use = m_ctrl[6] || (m_cnt == 0);
                m_ca_eff = m_use ? int'(m_ca) : m_ca_act;
                m_cb_eff = m_use ? int'(m_cb) : m_cb_act;
                m_ev[0] = (m_cnt == 0);
                m_ev[1] = (m_cnt == int'(m_prd));
                m_ev[2] = (m_cnt == m_ca_eff);
                m_ev[3] = (m_cnt == m_cb_eff);
                m_a = apply(m_a, m_acta, m_ev);
                m_b = apply(m_b, m_actb, m_ev);
                if (m_cnt == 0) begin m_ca_act = m_ca; m_cb_act = m_cb; end
                m_cnt = (m_cnt >= int'(m_prd)) ? 0 : m_cnt + 1;
            end
            if (m_ctrl[6]) begin m_ca_act = m_ca; m_cb_act = m_cb; end
            if (!en) begin m_cnt = 0; m_a = 0; m_b = 0; end
            if (m_evsel[2] && m_ev[m_evsel[1:0]]) m_irq = 1;
            else if (wr_en && wr_addr == 3'd7 && wr_data[0]) m_irq = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_ctrl  = wr_data[6:0];
                    3'd1: m_prd   = wr_data;
                    3'd2: m_ca    = wr_data;
                    3'd3: m_cb    = wr_data;
                    3'd4: m_acta  = wr_data;
                    3'd5: m_actb  = wr_data;
                    3'd6: m_evsel = wr_data[2:0];
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(cnt) == m_cnt, "R3 counter", int'(cnt), m_cnt);
            chk(pwm_a == m_a, "R4 output A", pwm_a, m_a);
            chk(pwm_b == m_b, "R4 output B", pwm_b, m_b);
            chk(irq == m_irq, "R8 flag", irq, m_irq);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (int'(cnt) != v);
    endtask

    task automatic measure(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        repeat (n) begin
            @(negedge clk);
            ha += int'(pwm_a);
            hb += int'(pwm_b);
        end
    endtask

    task automatic run_test;
        int ha, hb, k;
        bit b1, b2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cnt == 0, "R1 counter after reset", int'(cnt), 0);
        chk(pwm_a == 0 && pwm_b == 0, "R1 outputs after reset", int'({pwm_a, pwm_b}), 0);
        chk(irq == 0, "R1 flag after reset", irq, 0);

        // conventional PWM: P=9, A low at 4, B low at 7
        wr(3'd1, 16'd9);
        wr(3'd2, 16'd4);
        wr(3'd3, 16'd7);
        wr(3'd4, 16'h0012);
        wr(3'd5, 16'h0102);
        en = 1'b1;
        repeat (25) @(negedge clk);
        measure(10, ha, hb);
        chk(ha == 4, "R6 duty A=4", ha, 4);
        chk(hb == 7, "R6 duty B=7", hb, 7);

        // R7 shadow load: new compare waits for zero
        wait_cnt(2);
        wr(3'd2, 16'd8);
        wait_cnt(6);
        chk(pwm_a == 0, "R7 shadowed compare not yet used", pwm_a, 0);
        repeat (20) @(negedge clk);
        measure(10, ha, hb);
        chk(ha == 8, "R7 shadow value used next period", ha, 8);

        // R7 immediate load
        wr(3'd0, 16'h0040);
        wait_cnt(2);
        wr(3'd2, 16'd5);
        wait_cnt(7);
        chk(pwm_a == 0, "R7 immediate compare used in same period", pwm_a, 0);
        wr(3'd0, 16'h0000);

        // R6 duty extremes
        wr(3'd2, 16'd0);
        repeat (25) @(negedge clk);
        measure(10, ha, hb);
        chk(ha == 0, "R6 duty zero", ha, 0);
        wr(3'd2, 16'd10);
        repeat (25) @(negedge clk);
        measure(10, ha, hb);
        chk(ha == 10, "R6 duty P+1 full high", ha, 10);
        wr(3'd2, 16'd9);
        repeat (25) @(negedge clk);
        measure(10, ha, hb);
        chk(ha == 9, "R6 duty P", ha, 9);

        // R5 compare B beats compare A
        wr(3'd3, 16'd5);
        wr(3'd2, 16'd5);
        wr(3'd4, 16'h0211);
        repeat (25) @(negedge clk);
        measure(10, ha, hb);
        chk(ha == 5, "R5 compare-B over compare-A", ha, 5);

        // R4 toggle action on B
        wr(3'd5, 16'h0003);
        wait_cnt(3);
        b1 = pwm_b;
        wait_cnt(3);
        b2 = pwm_b;
        chk(b1 != b2, "R4 toggle on zero", int'(b2), int'(!b1));

        // R8/R9 interrupt flag
        wr(3'd6, 16'h0005);
        repeat (25) @(negedge clk);
        chk(irq == 1, "R8 period event sets flag", irq, 1);
        wait_cnt(2);
        wr(3'd7, 16'h0001);
        chk(irq == 0, "R9 clear", irq, 0);
        wait_cnt(9);
        wr(3'd7, 16'h0001);
        chk(irq == 1, "R9 set wins over clear", irq, 1);
        wr(3'd7, 16'h0000);
        chk(irq == 1, "R9 clear with bit0 low ignored", irq, 1);
        wait_cnt(2);
        wr(3'd7, 16'h0001);
        wr(3'd6, 16'h0001);
        repeat (25) @(negedge clk);
        chk(irq == 0, "R8 disabled interrupt never sets", irq, 0);
        wr(3'd6, 16'h0004);
        repeat (25) @(negedge clk);
        chk(irq == 1, "R8 zero event sets flag", irq, 1);
        wr(3'd6, 16'h0000);
        wait_cnt(2);
        wr(3'd7, 16'h0001);

        // R3 counter above a lowered period wraps
        wait_cnt(8);
        wr(3'd1, 16'd3);
        chk(cnt == 9, "R3 step before wrap", int'(cnt), 9);
        @(negedge clk);
        chk(cnt == 0, "R3 wrap when above period", int'(cnt), 0);
        wait_cnt(0);
        k = 0;
        do begin @(negedge clk); k++; end while (cnt != 0);
        chk(k == 4, "R3 period of P+1 ticks", k, 4);

        // R10 disable
        en = 1'b0;
        @(negedge clk);
        chk(cnt == 0 && pwm_a == 0 && pwm_b == 0, "R10 idle state",
            int'({cnt[3:0], pwm_a, pwm_b}), 0);

        // R2 divider 4 x 2
        wr(3'd0, 16'h000A);
        en = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (cnt != 1);
        chk(k == 8, "R2 divide by 8", k, 8);
        en = 1'b0;
        @(negedge clk);
        // divider 2 x 6
        wr(3'd0, 16'h0019);
        en = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (cnt != 1);
        chk(k == 12, "R2 divide by 12", k, 12);

        // R5 period beats zero when P=0
        en = 1'b0;
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd0);
        wr(3'd4, 16'h0009);
        en = 1'b1;
        repeat (5) @(negedge clk);
        chk(pwm_a == 1, "R5 period over zero", pwm_a, 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_test();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_err++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule